// File: doc/BRIEF.md
# Single-Wire Configuration Port

This block gives a host read and write access to a 128-bit configuration image over one bidirectional pin. The link is half duplex. Frames are asynchronous, with one start bit, 8 data bits sent least-significant bit first, no parity and one stop bit. The bit period is a fixed number of source-clock cycles, set by a parameter. The 128-bit image sits in a register array that stands in for non-volatile storage. The rest of the chip reads it in parallel on `cfg_o`.

After reset, a power-up delay counter holds the receiver off. Once the delay has run out, the block waits for an unlock byte. That byte moves it into access mode, and the block stays there until the next reset. In access mode, a write command is followed by sixteen data bytes, which are stored from byte 0 upward. A read command makes the block wait a short turnaround interval. It then drives the pin and sends out all sixteen bytes from byte 0 upward, and afterwards releases the pin. A host may repeat write and read bursts any number of times.

The receiver samples each bit at its middle. It discards a start bit that is no longer low at mid-bit. A frame whose stop bit is sampled low sets a framing-error flag and abandons any burst in progress.

Top module: `swu_cfg_port`

## Requirements
- R1: Transmitted frames use a bit period of BIT_CYCLES source cycles: one low start bit, then data bit 0 through bit 7, then one high stop bit.
- R2: Bytes are ignored until PWRUP_CYCLES cycles have passed since reset. After that, only byte 0xFD raises `access_mode_o`, and it stays high until reset.
- R3: In access mode, byte 0x00 starts a write. The next sixteen bytes land in `cfg_o`, with byte k stored at bits [8k+7:8k]. `cfg_o` changes at no other time.
- R4: In access mode, byte 0x40 starts a read. The block sends sixteen bytes, byte k being `cfg_o[8k+7:8k]`, in order from k = 0. `sp_oe_o` is high from the first start bit through the last stop bit and is low at every other time.
- R5: The first start bit of a read is driven between BIT_CYCLES/2 and BIT_CYCLES/2 + 6 cycles after the end of the read command's stop bit.
- R6: In access mode, any byte other than 0x00 or 0x40 that arrives outside a write burst is ignored.
- R7: A low pulse shorter than BIT_CYCLES/2 cycles is not taken as a start bit.
- R8: A stop bit sampled low sets `frame_err_o` and returns the block to waiting for a command. Bytes already stored in the aborted burst remain. The next correctly framed byte clears `frame_err_o`.
- R9: The block receives frames correctly when the host's bit period is 3 % shorter or longer than nominal.
- R10: Write and read bursts may be repeated; each new write replaces the whole image.
- R11: After reset, `access_mode_o`, `sp_oe_o`, `frame_err_o` and `cfg_o` are all zero, and `sp_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sp_i | input | 1 | Level sensed on the serial pin |
| sp_o | output | 1 | Serial data driven onto the pin |
| sp_oe_o | output | 1 | Pin output enable, high while the block drives |
| access_mode_o | output | 1 | High once the unlock byte has been accepted |
| frame_err_o | output | 1 | Last received frame had a low stop bit |
| cfg_o | output | 128 | Stored configuration image |

## Verification
The bench sends the unlock byte before the power-up delay has run out; a design that counted that byte would enter access mode early. It sends stray bytes before a command and checks that the image stays intact; a design that decoded too many opcodes would start a write. It also injects a short low glitch in the middle of a write burst; a receiver that does not re-check the start bit would store an extra 0xFF byte and shift the image. Other cases cover a broken stop bit inside a burst, which must abort the burst rather than go on counting bytes, and the turnaround delay, which is measured in cycles. Host bit periods 3 % off nominal expose a receiver that samples too close to the bit edges.

// File: rtl/swu_pkg.sv
package swu_pkg;
  localparam int BURST_BYTES = 16;
  localparam int CFG_BITS    = BURST_BYTES * 8;

  localparam logic [7:0] OP_UNLOCK = 8'hFD;
  localparam logic [7:0] OP_WRITE  = 8'h00;
  localparam logic [7:0] OP_READ   = 8'h40;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_LOCKED,
    ST_CMD,
    ST_WRITE,
    ST_GAP,
    ST_READ
  } ctrl_state_e;
endpackage

// File: rtl/swu_rx.sv
module swu_rx #(
  parameter int BIT_CYCLES = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       line_i,
  output logic       valid_o,
  output logic       ferr_o,
  output logic [7:0] data_o
);
  localparam int CW = $clog2(BIT_CYCLES);
  localparam logic [CW-1:0] BIT_LAST  = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(BIT_CYCLES / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  rx_state_e   st_q;
  logic [1:0]  sync_q;
  logic        prev_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]  nbit_q;
  logic [7:0]  sh_q;
  logic        line_s;

  assign line_s = sync_q[1];
  assign data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      prev_q  <= 1'b1;
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      nbit_q  <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], line_i};
      prev_q  <= line_s;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      case (st_q)
        RX_IDLE: if (en_i && prev_q && !line_s) begin
          st_q  <= RX_START;
          cnt_q <= '0;
        end
        RX_START: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == HALF_LAST) begin
            // reject glitches: line must still be low at mid start bit
            st_q   <= line_s ? RX_IDLE : RX_DATA;
            cnt_q  <= '0;
            nbit_q <= '0;
          end
        end
        RX_DATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == BIT_LAST) begin
            cnt_q  <= '0;
            sh_q   <= {line_s, sh_q[7:1]};
            nbit_q <= nbit_q + 1'b1;
            if (nbit_q == 3'd7) st_q <= RX_STOP;
          end
        end
        RX_STOP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == BIT_LAST) begin
            valid_o <= line_s;
            ferr_o  <= !line_s;
            st_q    <= RX_IDLE;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swu_tx.sv
module swu_tx #(
  parameter int BIT_CYCLES = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       done_o,
  output logic       line_o
);
  localparam int CW = $clog2(BIT_CYCLES);
  localparam logic [CW-1:0] BIT_LAST = CW'(BIT_CYCLES - 1);

  logic          busy_q;
  logic [9:0]    sh_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    nbit_q;

  assign line_o = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      nbit_q <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sh_q   <= {1'b1, data_i, 1'b0};
      cnt_q  <= '0;
      nbit_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == BIT_LAST) begin
          cnt_q  <= '0;
          sh_q   <= {1'b1, sh_q[9:1]};
          nbit_q <= nbit_q + 1'b1;
          if (nbit_q == 4'd9) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/swu_ctrl.sv
module swu_ctrl
  import swu_pkg::*;
#(
  parameter int BIT_CYCLES   = 512,
  parameter int PWRUP_CYCLES = 1200000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_valid_i,
  input  logic                rx_ferr_i,
  input  logic [7:0]          rx_data_i,
  input  logic                tx_done_i,
  output logic                rx_en_o,
  output logic                tx_start_o,
  output logic [7:0]          tx_data_o,
  output logic                oe_o,
  output logic                mode_o,
  output logic                ferr_o,
  output logic [CFG_BITS-1:0] cfg_o
);
  localparam int IW = $clog2(BURST_BYTES);
  localparam int CW = $clog2(BIT_CYCLES);
  localparam int PW = $clog2(PWRUP_CYCLES + 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(BURST_BYTES - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(BIT_CYCLES - 1);
  localparam logic [PW-1:0] PW_LAST  = PW'(PWRUP_CYCLES - 1);

  ctrl_state_e   st_q;
  logic [PW-1:0] pw_cnt_q;
  logic [CW-1:0] gap_cnt_q;
  logic [IW-1:0] idx_q, idx_nxt;
  logic [7:0]    mem_q [BURST_BYTES];

  for (genvar k = 0; k < BURST_BYTES; k++) begin : g_cfg
    assign cfg_o[8*k +: 8] = mem_q[k];
  end

  assign rx_en_o    = (st_q != ST_PWRUP) && !oe_o;
  assign idx_nxt    = (st_q == ST_GAP) ? '0 : idx_q + IW'(1);
  assign tx_data_o  = mem_q[idx_nxt];
  assign tx_start_o = (st_q == ST_GAP && gap_cnt_q == GAP_LAST) ||
                      (st_q == ST_READ && tx_done_i && idx_q != IDX_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_PWRUP;
      pw_cnt_q  <= '0;
      gap_cnt_q <= '0;
      idx_q     <= '0;
      oe_o      <= 1'b0;
      mode_o    <= 1'b0;
      ferr_o    <= 1'b0;
      for (int i = 0; i < BURST_BYTES; i++) mem_q[i] <= '0;
    end else begin
      if (rx_ferr_i) ferr_o <= 1'b1;
      else if (rx_valid_i) ferr_o <= 1'b0;
      case (st_q)
        ST_PWRUP: begin
          pw_cnt_q <= pw_cnt_q + 1'b1;
          if (pw_cnt_q == PW_LAST) st_q <= ST_LOCKED;
        end
        ST_LOCKED: if (rx_valid_i && rx_data_i == OP_UNLOCK) begin
          st_q   <= ST_CMD;
          mode_o <= 1'b1;
        end
        ST_CMD: if (rx_valid_i) begin
          idx_q     <= '0;
          gap_cnt_q <= '0;
          if (rx_data_i == OP_WRITE)     st_q <= ST_WRITE;
          else if (rx_data_i == OP_READ) st_q <= ST_GAP;
        end
        ST_WRITE: begin
          if (rx_ferr_i) begin
            st_q  <= ST_CMD;
            idx_q <= '0;
          end else if (rx_valid_i) begin
            mem_q[idx_q] <= rx_data_i;
            idx_q        <= idx_q + 1'b1;
            if (idx_q == IDX_LAST) st_q <= ST_CMD;
          end
        end
        ST_GAP: begin
          // half a bit after the command's stop bit ends
          gap_cnt_q <= gap_cnt_q + 1'b1;
          if (gap_cnt_q == GAP_LAST) begin
            st_q  <= ST_READ;
            oe_o  <= 1'b1;
            idx_q <= '0;
          end
        end
        ST_READ: if (tx_done_i) begin
          if (idx_q == IDX_LAST) begin
            oe_o  <= 1'b0;
            st_q  <= ST_CMD;
            idx_q <= '0;
          end else begin
            idx_q <= idx_nxt;
          end
        end
        default: st_q <= ST_PWRUP;
      endcase
    end
  end
endmodule

// File: rtl/swu_cfg_port.sv
module swu_cfg_port #(
  parameter int BIT_CYCLES   = 512,
  parameter int PWRUP_CYCLES = 1200000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sp_i,
  output logic                         sp_o,
  output logic                         sp_oe_o,
  output logic                         access_mode_o,
  output logic                         frame_err_o,
  output logic [swu_pkg::CFG_BITS-1:0] cfg_o
);
  logic       rx_en, rx_valid, rx_ferr, tx_start, tx_done;
  logic [7:0] rx_data, tx_data;

  swu_rx #(.BIT_CYCLES(BIT_CYCLES)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en),
    .line_i (sp_i),
    .valid_o(rx_valid),
    .ferr_o (rx_ferr),
    .data_o (rx_data)
  );

  swu_tx #(.BIT_CYCLES(BIT_CYCLES)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tx_start),
    .data_i (tx_data),
    .done_o (tx_done),
    .line_o (sp_o)
  );

  swu_ctrl #(.BIT_CYCLES(BIT_CYCLES), .PWRUP_CYCLES(PWRUP_CYCLES)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_valid_i(rx_valid),
    .rx_ferr_i (rx_ferr),
    .rx_data_i (rx_data),
    .tx_done_i (tx_done),
    .rx_en_o   (rx_en),
    .tx_start_o(tx_start),
    .tx_data_o (tx_data),
    .oe_o      (sp_oe_o),
    .mode_o    (access_mode_o),
    .ferr_o    (frame_err_o),
    .cfg_o     (cfg_o)
  );
endmodule

// File: rtl/swu_cfg_port_chk.sv
module swu_cfg_port_chk (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         sp_o,
  input logic                         sp_oe_o,
  input logic                         access_mode_o,
  input logic [swu_pkg::CFG_BITS-1:0] cfg_o
);
  // R4
  oe_needs_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_oe_o |-> access_mode_o);

  // R2
  mode_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_mode_o |=> access_mode_o);

  // R3
  cfg_hold_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_mode_o |=> $stable(cfg_o));

  // R4
  cfg_hold_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_oe_o |=> $stable(cfg_o));

  // R1
  released_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sp_oe_o |-> sp_o);

  // R5
  first_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sp_oe_o) |-> !sp_o);
endmodule

bind swu_cfg_port swu_cfg_port_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sp_o         (sp_o),
  .sp_oe_o      (sp_oe_o),
  .access_mode_o(access_mode_o),
  .cfg_o        (cfg_o)
);

// File: tb/tb_swu_cfg_port.sv
module tb_swu_cfg_port;
  localparam int BIT   = 32;
  localparam int HALF  = BIT / 2;
  localparam int PWRUP = 600;
  localparam int IDLE  = 64;
  localparam int NIMG  = 3;

  localparam logic [127:0] IMAGES [NIMG] = '{
    128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0,
    128'hFFFFFFFF000000005555AAAA0123ABCD,
    128'h80402010080402017E3CC3A55A81FE01
  };
  localparam logic [127:0] IMG_G  = 128'hDEADBEEF_CAFEF00D_13572468_9BDF0ACE;
  localparam logic [127:0] IMG_T1 = 128'h11223344_55667788_99AABBCC_DDEEFF00;
  localparam logic [127:0] IMG_T2 = 128'hA5A5A5A5_3C3C3C3C_0F0F0F0F_F0E1D2C3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         host_drv;
  wire          pin;
  logic         sp_o, sp_oe, mode, ferr;
  logic [127:0] cfg;

  assign pin = sp_oe ? sp_o : host_drv;

  swu_cfg_port #(.BIT_CYCLES(BIT), .PWRUP_CYCLES(PWRUP)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sp_i         (pin),
    .sp_o         (sp_o),
    .sp_oe_o      (sp_oe),
    .access_mode_o(mode),
    .frame_err_o  (ferr),
    .cfg_o        (cfg)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int per, input logic stop_bit, input int idle);
    host_drv = 1'b0;
    wait_cyc(per);
    for (int i = 0; i < 8; i++) begin
      host_drv = b[i];
      wait_cyc(per);
    end
    host_drv = stop_bit;
    wait_cyc(per);
    host_drv = 1'b1;
    wait_cyc(idle);
  endtask

  task automatic recv_byte(output logic [7:0] b, output logic ok);
    int t;
    t  = 0;
    ok = 1'b1;
    b  = '0;
    while (pin !== 1'b0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 3000) ok = 1'b0;
    wait_cyc(HALF);
    if (pin !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wait_cyc(BIT);
      b[i] = pin;
    end
    wait_cyc(BIT);
    if (pin !== 1'b1) ok = 1'b0;
  endtask

  task automatic write_image(input logic [127:0] img, input int per);
    send_byte(8'h00, per, 1'b1, IDLE);
    for (int k = 0; k < 16; k++) send_byte(img[8*k +: 8], per, 1'b1, IDLE);
  endtask

  task automatic read_image(output logic [127:0] img, output int turn, output logic ok);
    logic [7:0] b;
    logic       bok;
    img = '0;
    ok  = 1'b1;
    send_byte(8'h40, BIT, 1'b1, 0);
    turn = 0;
    while (!(sp_oe === 1'b1 && pin === 1'b0) && turn < 400) begin
      @(negedge clk);
      turn++;
    end
    for (int k = 0; k < 16; k++) begin
      recv_byte(b, bok);
      img[8*k +: 8] = b;
      ok = ok & bok;
    end
    wait_cyc(BIT);
  endtask

  initial begin
    logic [127:0] rd;
    logic [127:0] exp_img;
    int           turn;
    logic         ok;

    host_drv = 1'b1;
    rst_n    = 1'b0;
    wait_cyc(4);
    // R11 reset state
    chk("R11 access_mode_o", 128'(mode), 128'(0));
    chk("R11 sp_oe_o", 128'(sp_oe), 128'(0));
    chk("R11 sp_o", 128'(sp_o), 128'(1));
    chk("R11 frame_err_o", 128'(ferr), 128'(0));
    chk("R11 cfg_o", cfg, '0);
    rst_n = 1'b1;

    // R2 unlock byte during power-up delay is ignored
    send_byte(8'hFD, BIT, 1'b1, 4);
    chk("R2 unlock before delay", 128'(mode), 128'(0));
    wait_cyc(PWRUP);
    send_byte(8'h12, BIT, 1'b1, IDLE);
    chk("R2 wrong unlock byte", 128'(mode), 128'(0));
    send_byte(8'hFD, BIT, 1'b1, IDLE);
    chk("R2 unlock accepted", 128'(mode), 128'(1));

    // R6 stray bytes in access mode start nothing
    send_byte(8'h55, BIT, 1'b1, IDLE);
    for (int k = 0; k < 16; k++) send_byte(8'hAA, BIT, 1'b1, IDLE);
    chk("R6 image untouched", cfg, '0);
    chk("R6 pin not driven", 128'(sp_oe), 128'(0));

    read_image(rd, turn, ok);
    chk("R4 readback of reset image", rd, '0);
    chk("R1 frame format on readback", 128'(ok), 128'(1));
    chk("R5 turnaround lower bound", 128'(turn >= HALF), 128'(1));
    chk("R5 turnaround upper bound", 128'(turn <= HALF + 6), 128'(1));
    chk("R4 pin released after burst", 128'(sp_oe), 128'(0));

    // R10 table of images: write, check, read back
    for (int t = 0; t < NIMG; t++) begin
      write_image(IMAGES[t], BIT);
      chk("R3 R10 image stored", cfg, IMAGES[t]);
      read_image(rd, turn, ok);
      chk("R4 R10 image read back", rd, IMAGES[t]);
      chk("R1 readback frames", 128'(ok), 128'(1));
      chk("R4 released after read", 128'(sp_oe), 128'(0));
    end

    // R7 short glitch in the middle of a write burst
    send_byte(8'h00, BIT, 1'b1, IDLE);
    for (int k = 0; k < 8; k++) send_byte(IMG_G[8*k +: 8], BIT, 1'b1, IDLE);
    host_drv = 1'b0;
    wait_cyc(4);
    host_drv = 1'b1;
    wait_cyc(12 * BIT);
    for (int k = 8; k < 16; k++) send_byte(IMG_G[8*k +: 8], BIT, 1'b1, IDLE);
    chk("R7 glitch not a start bit", cfg, IMG_G);

    // R8 broken stop bit aborts a burst
    send_byte(8'h00, BIT, 1'b1, IDLE);
    send_byte(8'hA1, BIT, 1'b1, IDLE);
    send_byte(8'hB2, BIT, 1'b1, IDLE);
    send_byte(8'hC3, BIT, 1'b1, IDLE);
    send_byte(8'h77, BIT, 1'b0, IDLE);
    chk("R8 frame_err_o set", 128'(ferr), 128'(1));
    exp_img = {IMG_G[127:24], 24'hC3B2A1};
    chk("R8 partial bytes kept", cfg, exp_img);
    read_image(rd, turn, ok);
    chk("R8 command accepted after abort", rd, exp_img);
    chk("R8 frame_err_o cleared", 128'(ferr), 128'(0));

    // R9 host bit period off nominal
    write_image(IMG_T1, BIT - 1);
    chk("R9 short host bit period", cfg, IMG_T1);
    write_image(IMG_T2, BIT + 1);
    chk("R9 long host bit period", cfg, IMG_T2);
    chk("R2 still in access mode", 128'(mode), 128'(1));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule